// File: doc/BRIEF.md
# Page Access Rights Evaluator

This block decides whether one memory access to an already translated page may proceed. It combines three independent sources of permission into one set of read, write and execute rights. The first is a table lookup on the page's 3-bit protection code, selected by one of two segment key bits. The second is the page's no-execute and guarded attributes. The third is a pair of per-class mask registers indexed by the page's 5-bit class key. The requested access (load, store or instruction fetch) is then tested against the combined rights.

The outcome is a grant bit, the combined rights, and a set of syndrome flags that split a denial into its causes. Exception logic uses these flags to fill in its fault status. The evaluator sits after the page-table walk. The walker supplies the page entry fields, and the surrounding core supplies the privilege state and the mask registers. All results are registered, so the verdict for inputs presented before a rising clock edge appears just after that edge.

Top module: `prot_rights_eval`

## Requirements
- R1: The active key is `seg_key_user` when `user_mode` is 1 and `seg_key_sup` when `user_mode` is 0.
- R2: The protection code is {`prot_hi`, `prot_lo[1:0]`}. With key 0, codes 0, 1 and 2 give read+write+execute, codes 3 and 6 give read+execute, and codes 4, 5 and 7 give nothing.
- R3: With key 1, codes 0 and 6 give nothing, codes 1 and 3 give read+execute, code 2 gives read+write+execute, and codes 4, 5 and 7 give nothing.
- R4: If `no_exec` or `guarded` is 1, execute is removed and read and write are left untouched.
- R5: With `amask_en` at 1, class key k selects bits [2*(31-k)+1 : 2*(31-k)] of `amask`. The upper bit of that pair removes write and the lower bit removes read.
- R6: With `imask_en` at 1, bit 2*(31-k) of `imask` removes execute.
- R7: With `amask_en` at 0 the access mask removes nothing, and with `imask_en` at 0 the instruction mask removes nothing.
- R8: `rights` is {execute, write, read} (bit 2 to bit 0) after all terms are ANDed. `acc_type` 0 and 3 are loads and need read, 1 is a store and needs write, 2 is a fetch and needs execute. `granted` is 1 exactly when the needed right is present. A granted access raises no syndrome flag.
- R9: On a denied fetch, `flt_nxg` is set if no-execute/guarded removed execute. Otherwise `flt_prot` is set if the code table removed execute. `flt_mask` is additionally set if the instruction mask removed execute.
- R10: On a denied load or store, `flt_prot` is set if the code table lacks the needed right, `flt_mask` if the access mask removed it, and `flt_store` if the access is a store. `flt_nxg` stays 0.
- R11: All outputs are registered with one cycle of latency, and an active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_type | input | 2 | 0/3 load, 1 store, 2 instruction fetch |
| user_mode | input | 1 | 1 for an unprivileged access |
| seg_key_user | input | 1 | Segment key used in user mode |
| seg_key_sup | input | 1 | Segment key used in privileged mode |
| prot_lo | input | 2 | Low two protection bits of the page entry |
| prot_hi | input | 1 | Extra high protection bit of the page entry |
| no_exec | input | 1 | Page no-execute attribute |
| guarded | input | 1 | Page guarded attribute |
| class_key | input | 5 | Page class key |
| amask | input | 64 | Access mask register, 2 bits per class |
| imask | input | 64 | Instruction mask register, 2 bits per class |
| amask_en | input | 1 | Enables the access mask |
| imask_en | input | 1 | Enables the instruction mask |
| granted | output | 1 | Access allowed |
| rights | output | 3 | Combined {execute, write, read} |
| flt_prot | output | 1 | Denial caused by the protection code table |
| flt_nxg | output | 1 | Fetch denied by no-execute or guarded |
| flt_mask | output | 1 | Denial caused by a class mask |
| flt_store | output | 1 | Denied access was a store |

## Verification
Every cycle, the assertions check the consistency between the grant bit and the syndrome flags. A granted access carries no flag, and a denial carries at least one cause. They also check that the no-execute/guarded flag appears only on fetches, that the store flag appears only on denied stores, and that the no-execute or guarded attribute always clears the execute right. The exact contents of the two code tables, the bit position of each class field in the mask registers, the effect of the enables, and the priority between the no-execute and code-table causes can only be shown by the bench's scenarios, which compare the outputs against values worked out from the requirements.

// File: rtl/prot_eval_pkg.sv
package prot_eval_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'd0,
        ACC_STORE  = 2'd1,
        ACC_FETCH  = 2'd2,
        ACC_LOAD_B = 2'd3
    } acc_e;

    localparam int RT_RD = 0;
    localparam int RT_WR = 1;
    localparam int RT_EX = 2;

    typedef logic [2:0] rights_t;

    localparam rights_t RT_NONE = 3'b000;
    localparam rights_t RT_RX   = 3'b101;
    localparam rights_t RT_RWX  = 3'b111;

    typedef struct packed {
        logic    granted;
        rights_t rights;
        logic    f_prot;
        logic    f_nxg;
        logic    f_mask;
        logic    f_store;
    } verdict_t;

endpackage

// File: rtl/prot_code_rights.sv
module prot_code_rights
    import prot_eval_pkg::*;
(
    input  logic       key,
    input  logic [2:0] code,
    output rights_t    rights
);

    // Two lookup tables, one per key value; unlisted codes grant nothing.
    always_comb begin
        rights = RT_NONE;
        if (!key) begin
            case (code)
                3'd0, 3'd1, 3'd2: rights = RT_RWX;
                3'd3, 3'd6:       rights = RT_RX;
                default:          rights = RT_NONE;
            endcase
        end else begin
            case (code)
                3'd1, 3'd3: rights = RT_RX;
                3'd2:       rights = RT_RWX;
                default:    rights = RT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/prot_class_mask.sv
module prot_class_mask
    import prot_eval_pkg::*;
#(
    parameter  int NUM_CLASSES = 32,
    localparam int KEY_W       = $clog2(NUM_CLASSES),
    localparam int MASK_W      = 2 * NUM_CLASSES
) (
    input  logic [KEY_W-1:0]  class_key,
    input  logic [MASK_W-1:0] amask,
    input  logic [MASK_W-1:0] imask,
    input  logic              amask_en,
    input  logic              imask_en,
    output rights_t           mask_rights
);

    logic [1:0] a_fld [NUM_CLASSES];
    logic       i_fld [NUM_CLASSES];

    // Class 0 owns the most significant pair of each register.
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_fld
        localparam int OFS = 2 * (NUM_CLASSES - 1 - c);
        assign a_fld[c] = amask[OFS +: 2];
        assign i_fld[c] = imask[OFS];
    end

    logic [1:0] a_sel;
    logic       i_sel;

    always_comb begin
        a_sel = a_fld[class_key];
        i_sel = i_fld[class_key];
        mask_rights        = RT_RWX;
        if (amask_en) begin
            mask_rights[RT_WR] = ~a_sel[1];
            mask_rights[RT_RD] = ~a_sel[0];
        end
        if (imask_en) begin
            mask_rights[RT_EX] = ~i_sel;
        end
    end

endmodule

// File: rtl/prot_syndrome.sv
module prot_syndrome
    import prot_eval_pkg::*;
(
    input  acc_e     acc,
    input  rights_t  pp_rights,
    input  logic     exec_ok,
    input  rights_t  mask_rights,
    output verdict_t verdict
);

    rights_t    nxg_rights;
    rights_t    total;
    logic [1:0] need;
    logic       is_fetch;

    always_comb begin
        nxg_rights = {exec_ok, 2'b11};
        total      = pp_rights & nxg_rights & mask_rights;
        is_fetch   = (acc == ACC_FETCH);
        case (acc)
            ACC_STORE: need = 2'(RT_WR);
            ACC_FETCH: need = 2'(RT_EX);
            default:   need = 2'(RT_RD);
        endcase

        verdict         = '0;
        verdict.rights  = total;
        verdict.granted = total[need];
        if (!verdict.granted) begin
            if (is_fetch) begin
                // No-execute/guard cause outranks the code-table cause.
                verdict.f_nxg  = ~exec_ok;
                verdict.f_prot = exec_ok & ~pp_rights[RT_EX];
                verdict.f_mask = ~mask_rights[RT_EX];
            end else begin
                verdict.f_prot  = ~pp_rights[need];
                verdict.f_mask  = ~mask_rights[need];
                verdict.f_store = (acc == ACC_STORE);
            end
        end
    end

endmodule

// File: rtl/prot_rights_eval.sv
module prot_rights_eval
    import prot_eval_pkg::*;
#(
    parameter  int NUM_CLASSES = 32,
    localparam int KEY_W       = $clog2(NUM_CLASSES),
    localparam int MASK_W      = 2 * NUM_CLASSES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_type,
    input  logic              user_mode,
    input  logic              seg_key_user,
    input  logic              seg_key_sup,
    input  logic [1:0]        prot_lo,
    input  logic              prot_hi,
    input  logic              no_exec,
    input  logic              guarded,
    input  logic [KEY_W-1:0]  class_key,
    input  logic [MASK_W-1:0] amask,
    input  logic [MASK_W-1:0] imask,
    input  logic              amask_en,
    input  logic              imask_en,
    output logic              granted,
    output logic [2:0]        rights,
    output logic              flt_prot,
    output logic              flt_nxg,
    output logic              flt_mask,
    output logic              flt_store
);

    logic     key_sel;
    logic     exec_ok;
    rights_t  pp_rights;
    rights_t  mask_rights;
    verdict_t st_d;
    verdict_t st_q;

    always_comb begin
        key_sel = user_mode ? seg_key_user : seg_key_sup;
        exec_ok = ~(no_exec | guarded);
    end

    prot_code_rights u_code (
        .key    (key_sel),
        .code   ({prot_hi, prot_lo}),
        .rights (pp_rights)
    );

    prot_class_mask #(
        .NUM_CLASSES (NUM_CLASSES)
    ) u_mask (
        .class_key   (class_key),
        .amask       (amask),
        .imask       (imask),
        .amask_en    (amask_en),
        .imask_en    (imask_en),
        .mask_rights (mask_rights)
    );

    prot_syndrome u_syn (
        .acc         (acc_e'(acc_type)),
        .pp_rights   (pp_rights),
        .exec_ok     (exec_ok),
        .mask_rights (mask_rights),
        .verdict     (st_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign granted   = st_q.granted;
    assign rights    = st_q.rights;
    assign flt_prot  = st_q.f_prot;
    assign flt_nxg   = st_q.f_nxg;
    assign flt_mask  = st_q.f_mask;
    assign flt_store = st_q.f_store;

endmodule

// File: rtl/prot_rights_chk.sv
module prot_rights_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] acc_type,
    input logic       no_exec,
    input logic       guarded,
    input logic       granted,
    input logic [2:0] rights,
    input logic       flt_prot,
    input logic       flt_nxg,
    input logic       flt_mask,
    input logic       flt_store
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        granted |-> !(flt_prot || flt_nxg || flt_mask || flt_store)); // R8

    AST_DENY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !granted) |-> (flt_prot || flt_nxg || flt_mask)); // R9

    AST_NXG_KILLS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(no_exec || guarded)) |-> !rights[2]); // R4

    AST_NXG_FETCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && flt_nxg) |-> ($past(acc_type) == 2'd2)); // R9

    AST_STORE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && flt_store) |-> ($past(acc_type) == 2'd1 && !granted)); // R10

    AST_DATA_NO_NXG: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(acc_type) != 2'd2) |-> !flt_nxg); // R10

endmodule

bind prot_rights_eval prot_rights_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_type  (acc_type),
    .no_exec   (no_exec),
    .guarded   (guarded),
    .granted   (granted),
    .rights    (rights),
    .flt_prot  (flt_prot),
    .flt_nxg   (flt_nxg),
    .flt_mask  (flt_mask),
    .flt_store (flt_store)
);

// File: tb/prot_rights_eval_tb.sv
`timescale 1ns/1ps
module prot_rights_eval_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_type = 2'd0;
    logic        user_mode = 1'b0;
    logic        seg_key_user = 1'b0;
    logic        seg_key_sup = 1'b0;
    logic [1:0]  prot_lo = 2'd0;
    logic        prot_hi = 1'b0;
    logic        no_exec = 1'b0;
    logic        guarded = 1'b0;
    logic [4:0]  class_key = 5'd0;
    logic [63:0] amask = '0;
    logic [63:0] imask = '0;
    logic        amask_en = 1'b0;
    logic        imask_en = 1'b0;
    logic        granted;
    logic [2:0]  rights;
    logic        flt_prot, flt_nxg, flt_mask, flt_store;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prot_rights_eval u_dut (
        .clk(clk), .rst_n(rst_n), .acc_type(acc_type), .user_mode(user_mode),
        .seg_key_user(seg_key_user), .seg_key_sup(seg_key_sup),
        .prot_lo(prot_lo), .prot_hi(prot_hi), .no_exec(no_exec),
        .guarded(guarded), .class_key(class_key), .amask(amask),
        .imask(imask), .amask_en(amask_en), .imask_en(imask_en),
        .granted(granted), .rights(rights), .flt_prot(flt_prot),
        .flt_nxg(flt_nxg), .flt_mask(flt_mask), .flt_store(flt_store)
    );

    function automatic logic [7:0] got_v();
        return {granted, rights, flt_prot, flt_nxg, flt_mask, flt_store};
    endfunction

    // Expected verdict {grant, rights[2:0], prot, nxg, mask, store} from the requirements.
    function automatic logic [7:0] model();
        logic       key;
        logic [2:0] code, pp, nx, mk, tot;
        int         ofs, need;
        logic       g, fp, fn, fm, fs;
        key  = user_mode ? seg_key_user : seg_key_sup;          // R1
        code = {prot_hi, prot_lo};
        if (!key) pp = (code <= 2) ? 3'b111 : (code == 3 || code == 6) ? 3'b101 : 3'b000; // R2
        else      pp = (code == 2) ? 3'b111 : (code == 1 || code == 3) ? 3'b101 : 3'b000; // R3
        nx  = (no_exec || guarded) ? 3'b011 : 3'b111;           // R4
        ofs = 2 * (31 - int'(class_key));
        mk  = 3'b111;
        if (amask_en) begin mk[1] = ~amask[ofs+1]; mk[0] = ~amask[ofs]; end // R5 R7
        if (imask_en) mk[2] = ~imask[ofs];                      // R6
        tot  = pp & nx & mk;
        need = (acc_type == 2'd1) ? 1 : (acc_type == 2'd2) ? 2 : 0;
        g = tot[need];
        fp = 0; fn = 0; fm = 0; fs = 0;
        if (!g) begin
            if (acc_type == 2'd2) begin
                fn = ~nx[2]; fp = nx[2] & ~pp[2]; fm = ~mk[2];
            end else begin
                fp = ~pp[need]; fm = ~mk[need]; fs = (acc_type == 2'd1);
            end
        end
        return {g, tot, fp, fn, fm, fs};
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Inputs already set; register them and compare against the model.
    task automatic step(string req);
        logic [7:0] e;
        e = model();
        @(posedge clk);
        @(negedge clk);
        chk(req, got_v(), e);
    endtask

    task automatic clear_inputs();
        acc_type = 0; user_mode = 0; seg_key_user = 0; seg_key_sup = 0;
        prot_lo = 0; prot_hi = 0; no_exec = 0; guarded = 0; class_key = 0;
        amask = '0; imask = '0; amask_en = 0; imask_en = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 reset", got_v(), 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_key_select();
        clear_inputs();
        prot_lo = 2'd0; acc_type = 2'd0;
        user_mode = 1; seg_key_user = 1; seg_key_sup = 0;
        step("R1 user key=1 code0");
        chk("R1 user denied", {granted, flt_prot}, 2'b01);
        user_mode = 0;
        step("R1 sup key=0 code0");
        chk("R1 sup granted", {granted, rights}, 4'b1111);
    endtask

    task automatic t_tables();
        clear_inputs();
        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < 8; c++) begin
                seg_key_sup = k[0]; {prot_hi, prot_lo} = c[2:0]; acc_type = 2'd0;
                step(k == 0 ? "R2 table key0" : "R3 table key1");
            end
        end
        seg_key_sup = 0; {prot_hi, prot_lo} = 3'd3; acc_type = 2'd0;
        step("R2 code3");
        chk("R2 code3 rights", {29'd0, rights}, 32'd5);
        seg_key_sup = 1; {prot_hi, prot_lo} = 3'd6;
        step("R3 code6");
        chk("R3 code6 rights", {29'd0, rights}, 32'd0);
    endtask

    task automatic t_nxg();
        clear_inputs();
        acc_type = 2'd2; no_exec = 1;
        step("R4 no_exec fetch");
        chk("R4 no_exec rights", {granted, rights, flt_nxg, flt_prot}, 6'b001110);
        no_exec = 0; guarded = 1; acc_type = 2'd1;
        step("R4 guarded store ok");
        chk("R4 guarded keeps write", {granted, rights}, 4'b1011);
    endtask

    task automatic t_amask();
        clear_inputs();
        amask_en = 1;
        class_key = 5'd0; amask = 64'h8000_0000_0000_0000; acc_type = 2'd1;
        step("R5 class0 write off");
        chk("R5 class0 store", {granted, rights, flt_mask, flt_store, flt_prot}, 7'b0101110);
        class_key = 5'd31; amask = 64'h1; acc_type = 2'd0;
        step("R5 class31 read off");
        chk("R5 class31 load", {granted, flt_mask}, 2'b01);
        class_key = 5'd30; acc_type = 2'd0;
        step("R5 other class unaffected");
        chk("R5 class30 load", granted, 1'b1);
        class_key = 5'd9; amask = 64'h3 << (2 * (31 - 9));
        {prot_hi, prot_lo} = 3'd5; acc_type = 2'd1;
        step("R10 both causes");
    endtask

    task automatic t_imask();
        clear_inputs();
        class_key = 5'd4; imask = 64'h1 << (2 * (31 - 4)); acc_type = 2'd2;
        imask_en = 1;
        step("R6 imask fetch deny");
        chk("R6 imask flags", {granted, flt_mask, flt_nxg, flt_prot}, 4'b0100);
        imask = 64'h2 << (2 * (31 - 4));
        step("R6 upper bit ignored");
        chk("R6 upper bit", granted, 1'b1);
    endtask

    task automatic t_disabled();
        clear_inputs();
        amask = '1; imask = '1; class_key = 5'd17;
        for (int a = 0; a < 3; a++) begin
            acc_type = a[1:0];
            step("R7 masks disabled");
            chk("R7 grant", granted, 1'b1);
        end
    endtask

    task automatic t_fetch_priority();
        clear_inputs();
        seg_key_sup = 1; prot_lo = 2'd0; guarded = 1; imask_en = 1; imask = '1;
        acc_type = 2'd2;
        step("R9 nxg over prot");
        chk("R9 flags", {flt_nxg, flt_prot, flt_mask}, 3'b101);
        guarded = 0;
        step("R9 prot cause");
        chk("R9 prot flags", {flt_nxg, flt_prot, flt_mask}, 3'b011);
    endtask

    task automatic t_grant_sweep();
        clear_inputs();
        for (int u = 0; u < 2; u++)
            for (int k = 0; k < 4; k++)
                for (int c = 0; c < 8; c++)
                    for (int a = 0; a < 4; a++) begin
                        user_mode = u[0]; {seg_key_user, seg_key_sup} = k[1:0];
                        {prot_hi, prot_lo} = c[2:0]; acc_type = a[1:0];
                        no_exec = c[0] & k[0]; guarded = a[0] & u[0];
                        amask_en = k[1]; amask = 64'h5A5A_A5A5_3C3C_C3C3;
                        imask_en = c[1]; imask = 64'hF0F0_0F0F_9999_6666;
                        class_key = 5'(c * 4 + a);
                        step("R8 sweep");
                    end
    endtask

    task automatic t_latency();
        clear_inputs();
        acc_type = 2'd0;
        step("R11 grant first");
        seg_key_sup = 1; prot_lo = 2'd0;
        #1;
        chk("R11 holds before edge", {7'd0, granted}, 8'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R11 updates after edge", {7'd0, granted}, 8'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_key_select();
        t_tables();
        t_nxg();
        t_amask();
        t_imask();
        t_disabled();
        t_fetch_priority();
        t_grant_sweep();
        t_latency();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule